// File: doc/BRIEF.md
# Power-Indexed Complex Gain Predistorter

This block sits in front of a power amplifier's transmit chain. Each complex baseband sample (I, Q) is multiplied by a complex correction gain taken from a 256-entry on-chip table. The table index comes from the sample's instantaneous power I²+Q². When memory-effect mode is on, the index comes instead from a four-tap weighted sum of the current power and the powers of the three previous accepted samples. The product is rounded to nearest, saturated to 16 bits and presented five register stages after the sample is accepted.

Alongside each result the block outputs the original input sample, the table address that was used and the gain that was applied. An external adaptation loop can then compare the input with the amplifier's feedback and correct exactly the entry that shaped that sample. The table and the tap weights can both be rewritten at any time, including while samples stream through. Every entry resets to unity gain, so before adaptation the block passes samples through unchanged.

Top module: `dpd_lut_corrector`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and out_i, out_q, fb_i, fb_q, fb_addr, fb_gain_i and fb_gain_q are 0. Every table entry is 0x4000 (real) / 0x0000 (imaginary), the tap weights are {0x80, 0, 0, 0} and the power history is zero.
- R2: With mem_en low, the address is formed from p = I²+Q² of the sample. If p ≥ 2^31 the address is 255; otherwise it is bits [30:23] of p.
- R3: With mem_en high, S = w0·p0 + w1·p1 + w2·p2 + w3·p3. Here p0 is the current power and p1..p3 are the powers of the three previously accepted samples, newest first, counting zero before any exist. The weights w are unsigned with 7 fraction bits (0x80 = 1.0). The address is computed from floor(S/128) by the rule of R2. With mem_en low the weights have no effect.
- R4: A table entry holds a signed 16-bit real gain and a signed 16-bit imaginary gain, each with 14 fraction bits. fb_gain_i/fb_gain_q show the entry that was read at fb_addr for that sample.
- R5: out_i = round(I·gI − Q·gQ) and out_q = round(I·gQ + Q·gI), computed as floor((x + 2^13) / 2^14) and saturated to [−32768, 32767].
- R6: A sample accepted (in_valid high) on rising edge n produces out_valid high after edge n+4. At any other time out_valid is low, and all data outputs hold their previous values.
- R7: fb_i and fb_q carry the input sample, updated together with out_i/out_q.
- R8: A table write with lut_we high on edge m updates entry lut_waddr. A sample accepted on edge n reads the table on edge n+2, so it sees writes made on edges up to n+1. A write on edge n+2 to the same entry is not seen (the read returns the old value).
- R9: With tap_we high on edge m, tap_sel selects which weight takes tap_wdata. A sample accepted on edge n uses the weights as written up to edge n and the mem_en level present at edge n+1.
- R10: When the applied gain is exactly 0x4000 / 0x0000, out_i and out_q equal the input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | Input real part, signed |
| in_q | input | 16 | Input imaginary part, signed |
| mem_en | input | 1 | Selects weighted-history addressing |
| tap_we | input | 1 | Tap weight write strobe |
| tap_sel | input | 2 | Tap weight index (0 = current power) |
| tap_wdata | input | 8 | Tap weight, unsigned, 7 fraction bits |
| lut_we | input | 1 | Table write strobe |
| lut_waddr | input | 8 | Table write address |
| lut_wgain_i | input | 16 | Real gain to write, Q2.14 |
| lut_wgain_q | input | 16 | Imaginary gain to write, Q2.14 |
| out_valid | output | 1 | Output qualifier |
| out_i | output | 16 | Corrected real part |
| out_q | output | 16 | Corrected imaginary part |
| fb_i | output | 16 | Delayed input real part |
| fb_q | output | 16 | Delayed input imaginary part |
| fb_addr | output | 8 | Table address used for this sample |
| fb_gain_i | output | 16 | Real gain applied |
| fb_gain_q | output | 16 | Imaginary gain applied |

## Verification
The assertions check a set of properties on every cycle. The output qualifier follows the input qualifier five cycles later. The data outputs hold while idle. The returned input copy matches the sample taken five cycles earlier. In direct mode the reported address matches the power of that sample, and a unity gain passes the sample through untouched. Other behaviours depend on table and weight contents and their history, and only the bench's scenarios can show them: the weighted-history address and its saturation, rounding and clipping of the complex product, and the cycle at which a live table or weight write first becomes visible, including the same-cycle read-old case.

// File: rtl/dpd_lut_corrector.sv
module dpd_lut_corrector #(
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int GF = 14,
  parameter int AW = 8,
  parameter int WW = 8,
  parameter int WF = 7,
  parameter int NT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 mem_en,
  input  logic                 tap_we,
  input  logic [((NT > 1) ? $clog2(NT) : 1)-1:0] tap_sel,
  input  logic [WW-1:0]        tap_wdata,
  input  logic                 lut_we,
  input  logic [AW-1:0]        lut_waddr,
  input  logic signed [GW-1:0] lut_wgain_i,
  input  logic signed [GW-1:0] lut_wgain_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic signed [DW-1:0] fb_i,
  output logic signed [DW-1:0] fb_q,
  output logic [AW-1:0]        fb_addr,
  output logic signed [GW-1:0] fb_gain_i,
  output logic signed [GW-1:0] fb_gain_q
);

  localparam int PW    = 2*DW + 1;
  localparam int PTOP  = 2*DW - 1;
  localparam int SW    = PW + WW + $clog2(NT) + 1;
  localparam int MW    = DW + GW + 2;
  localparam int DEPTH = 1 << AW;
  localparam logic [SW-1:0]        PSAT  = SW'(1) << PTOP;
  localparam logic [GW-1:0]        UNITY = GW'(1) << GF;
  localparam logic signed [MW-1:0] RND   = MW'(64'sd1 << (GF-1));
  localparam logic signed [MW-1:0] OMAX  = MW'((64'sd1 << (DW-1)) - 64'sd1);
  localparam logic signed [MW-1:0] OMIN  = ~OMAX;

  function automatic logic [AW-1:0] sat_addr(input logic [SW-1:0] v);
    if (v >= PSAT) return '1;
    return v[PTOP-1 -: AW];
  endfunction

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [MW-1:0] v);
    logic signed [MW-1:0] r;
    r = (v + RND) >>> GF;
    if (r > OMAX) return OMAX[DW-1:0];
    if (r < OMIN) return OMIN[DW-1:0];
    return r[DW-1:0];
  endfunction

  logic [WW-1:0]   taps [NT];
  logic [2*GW-1:0] lut  [DEPTH];
  logic [PW-1:0]   hist [1:NT-1];

  logic s1_v, s2_v, s3_v, s4_v;
  logic signed [DW-1:0] s1_i, s1_q, s2_i, s2_q, s3_i, s3_q, s4_i, s4_q;
  logic [PW-1:0]        s1_pow;
  logic [AW-1:0]        s2_addr, s3_addr, s4_addr;
  logic signed [GW-1:0] s3_gi, s3_gq, s4_gi, s4_gq;
  logic signed [MW-1:0] s4_re, s4_im;

  logic signed [2*DW-1:0] sq_i, sq_q;
  logic [PW-1:0]          pow_now;
  logic [SW-1:0]          wsum;
  logic [AW-1:0]          addr_sel;
  logic signed [MW-1:0]   prod_re, prod_im;

  assign sq_i    = in_i * in_i;
  assign sq_q    = in_q * in_q;
  assign pow_now = PW'($unsigned(sq_i)) + PW'($unsigned(sq_q));

  always_comb begin
    wsum = SW'(taps[0]) * SW'(s1_pow);
    for (int k = 1; k < NT; k++) wsum = wsum + SW'(taps[k]) * SW'(hist[k]);
  end

  assign addr_sel = mem_en ? sat_addr(wsum >> WF) : sat_addr(SW'(s1_pow));
  assign prod_re  = s3_i * s3_gi - s3_q * s3_gq;
  assign prod_im  = s3_i * s3_gq + s3_q * s3_gi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) taps[k] <= (k == 0) ? WW'(1 << WF) : '0;
      for (int d = 0; d < DEPTH; d++) lut[d] <= {UNITY, GW'(0)};
      for (int k = 1; k < NT; k++) hist[k] <= '0;
    end else begin
      if (tap_we) taps[tap_sel] <= tap_wdata;
      if (lut_we) lut[lut_waddr] <= {lut_wgain_i, lut_wgain_q};
      if (s1_v) begin
        hist[1] <= s1_pow;
        for (int k = 2; k < NT; k++) hist[k] <= hist[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1_v, s2_v, s3_v, s4_v, out_valid} <= '0;
      out_i     <= '0;
      out_q     <= '0;
      fb_i      <= '0;
      fb_q      <= '0;
      fb_addr   <= '0;
      fb_gain_i <= '0;
      fb_gain_q <= '0;
    end else begin
      s1_v      <= in_valid;
      s2_v      <= s1_v;
      s3_v      <= s2_v;
      s4_v      <= s3_v;
      out_valid <= s4_v;
      if (s4_v) begin
        out_i     <= rnd_sat(s4_re);
        out_q     <= rnd_sat(s4_im);
        fb_i      <= s4_i;
        fb_q      <= s4_q;
        fb_addr   <= s4_addr;
        fb_gain_i <= s4_gi;
        fb_gain_q <= s4_gq;
      end
    end
  end

  always_ff @(posedge clk) begin
    s1_i    <= in_i;
    s1_q    <= in_q;
    s1_pow  <= pow_now;
    s2_i    <= s1_i;
    s2_q    <= s1_q;
    s2_addr <= addr_sel;
    s3_i    <= s2_i;
    s3_q    <= s2_q;
    s3_addr <= s2_addr;
    s3_gi   <= lut[s2_addr][2*GW-1:GW];
    s3_gq   <= lut[s2_addr][GW-1:0];
    s4_i    <= s3_i;
    s4_q    <= s3_q;
    s4_addr <= s3_addr;
    s4_gi   <= s3_gi;
    s4_gq   <= s3_gq;
    s4_re   <= prod_re;
    s4_im   <= prod_im;
  end

endmodule

// File: rtl/dpd_lut_corrector_chk.sv
module dpd_lut_corrector_chk #(
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int GF = 14,
  parameter int AW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 mem_en,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q,
  input logic signed [DW-1:0] fb_i,
  input logic signed [DW-1:0] fb_q,
  input logic [AW-1:0]        fb_addr,
  input logic signed [GW-1:0] fb_gain_i,
  input logic signed [GW-1:0] fb_gain_q
);

  localparam logic [GW-1:0] ONE = GW'(1) << GF;

  function automatic logic [AW-1:0] addr_of(input logic signed [DW-1:0] a,
                                            input logic signed [DW-1:0] b);
    logic signed [2*DW-1:0] sa, sb;
    logic [2*DW:0] p;
    sa = a * a;
    sb = b * b;
    p  = {1'b0, sa} + {1'b0, sb};
    if (p[2*DW] || p[2*DW-1]) return '1;
    return p[2*DW-2 -: AW];
  endfunction

  logic [2:0] since_rst;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end
  assign warm = (since_rst >= 3'd5);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 5))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_i) && $stable(out_q) && $stable(fb_addr) && $stable(fb_gain_i))); // R6

  AST_FB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid) |-> (fb_i == $past(in_i, 5) && fb_q == $past(in_q, 5))); // R7

  AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !$past(mem_en, 4)) |-> (fb_addr == addr_of($past(in_i, 5), $past(in_q, 5)))); // R2

  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fb_gain_i == ONE && fb_gain_q == '0) |-> (out_i == fb_i && out_q == fb_q)); // R10

endmodule

bind dpd_lut_corrector dpd_lut_corrector_chk #(.DW(DW), .GW(GW), .GF(GF), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .mem_en(mem_en), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
  .fb_i(fb_i), .fb_q(fb_q), .fb_addr(fb_addr),
  .fb_gain_i(fb_gain_i), .fb_gain_q(fb_gain_q)
);

// File: tb/dpd_lut_corrector_tb.sv
module dpd_lut_corrector_tb;
  localparam int CLK_PERIOD = 10;
  localparam longint WD_LIMIT = 150000;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, mem_en = 0, tap_we = 0, lut_we = 0;
  logic signed [15:0] in_i = 0, in_q = 0, lut_wgain_i = 0, lut_wgain_q = 0;
  logic [1:0] tap_sel = 0;
  logic [7:0] tap_wdata = 0, lut_waddr = 0;
  logic out_valid;
  logic signed [15:0] out_i, out_q, fb_i, fb_q, fb_gain_i, fb_gain_q;
  logic [7:0] fb_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpd_lut_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .mem_en(mem_en), .tap_we(tap_we), .tap_sel(tap_sel), .tap_wdata(tap_wdata),
    .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wgain_i(lut_wgain_i),
    .lut_wgain_q(lut_wgain_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .fb_i(fb_i), .fb_q(fb_q), .fb_addr(fb_addr), .fb_gain_i(fb_gain_i),
    .fb_gain_q(fb_gain_q)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  longint cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  typedef struct {
    longint acc;
    int vi, vq;
    longint pw;
    int addr, gi, gq;
    bit mem;
  } item_t;

  item_t  pend[$];
  int     m_gi[256], m_gq[256];
  int     m_tap[4];
  longint m_hist[3];

  function automatic int addr_rule(longint s);
    if (s >= 64'd2147483648) return 255;
    return int'((s >> 23) & 255);
  endfunction

  function automatic int rsat(longint x);
    longint r;
    r = (x + 8192) >>> 14;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      pend.delete();
      for (int d = 0; d < 256; d++) begin m_gi[d] = 16384; m_gq[d] = 0; end
      m_tap[0] = 128; m_tap[1] = 0; m_tap[2] = 0; m_tap[3] = 0;
      for (int k = 0; k < 3; k++) m_hist[k] = 0;
    end else begin
      foreach (pend[k]) begin
        if (pend[k].acc + 1 == cyc) begin
          longint s;
          pend[k].mem = mem_en;
          if (mem_en) begin
            s = m_tap[0] * pend[k].pw + m_tap[1] * m_hist[0]
              + m_tap[2] * m_hist[1] + m_tap[3] * m_hist[2];
            pend[k].addr = addr_rule(s / 128);
          end else begin
            pend[k].addr = addr_rule(pend[k].pw);
          end
          m_hist[2] = m_hist[1];
          m_hist[1] = m_hist[0];
          m_hist[0] = pend[k].pw;
        end
        if (pend[k].acc + 2 == cyc) begin
          pend[k].gi = m_gi[pend[k].addr];
          pend[k].gq = m_gq[pend[k].addr];
        end
      end
      if (lut_we) begin
        m_gi[lut_waddr] = int'(lut_wgain_i);
        m_gq[lut_waddr] = int'(lut_wgain_q);
      end
      if (tap_we) m_tap[tap_sel] = int'(tap_wdata);
      if (in_valid) begin
        item_t it;
        it.acc = cyc;
        it.vi = int'(in_i);
        it.vq = int'(in_q);
        it.pw = longint'(it.vi) * it.vi + longint'(it.vq) * it.vq;
        it.addr = 0; it.gi = 0; it.gq = 0; it.mem = 0;
        pend.push_back(it);
      end
    end
  end

  // comparison on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pend.size() > 0 && pend[0].acc + 4 == cyc) begin
        item_t it;
        int eo_i, eo_q;
        string rq;
        it = pend.pop_front();
        eo_i = rsat(longint'(it.vi) * it.gi - longint'(it.vq) * it.gq);
        eo_q = rsat(longint'(it.vi) * it.gq + longint'(it.vq) * it.gi);
        rq = (it.gi == 16384 && it.gq == 0) ? "R10" : "R5";
        chk(out_valid == 1'b1, "R6 valid", out_valid, 1);
        chk(int'(out_i) == eo_i, {rq, " out_i"}, out_i, eo_i);
        chk(int'(out_q) == eo_q, {rq, " out_q"}, out_q, eo_q);
        chk(int'(fb_i) == it.vi, "R7 fb_i", fb_i, it.vi);
        chk(int'(fb_q) == it.vq, "R7 fb_q", fb_q, it.vq);
        chk(int'(fb_addr) == it.addr, it.mem ? "R3,R9 addr" : "R2 addr", fb_addr, it.addr);
        chk(int'(fb_gain_i) == it.gi, "R4,R8 gain_i", fb_gain_i, it.gi);
        chk(int'(fb_gain_q) == it.gq, "R4,R8 gain_q", fb_gain_q, it.gq);
      end else begin
        chk(out_valid == 1'b0, "R6 idle", out_valid, 0);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    if (!done && cyc > WD_LIMIT) begin
      done = 1;
      failures++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  function automatic logic [15:0] pick(int m);
    int r;
    r = int'($urandom % 8);
    if (m == 1) return ($urandom % 2) ? 16'h7fff : 16'h8000;
    if (m == 2) return 16'(int'($urandom % 9) - 4);
    if (r == 0) return 16'h8000;
    if (r == 1) return 16'h7fff;
    if (r == 2) return 16'h0000;
    return 16'($urandom);
  endfunction

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 0; lut_we = 0; tap_we = 0;
    end
  endtask

  task automatic wr_lut(int a, int gi, int gq);
    @(negedge clk);
    in_valid = 0; tap_we = 0; lut_we = 1;
    lut_waddr = 8'(a); lut_wgain_i = 16'(gi); lut_wgain_q = 16'(gq);
  endtask

  task automatic wr_tap(int s, int w);
    @(negedge clk);
    in_valid = 0; lut_we = 0; tap_we = 1;
    tap_sel = 2'(s); tap_wdata = 8'(w);
  endtask

  task automatic stream(int n, int vpct, int wpct, int tpct, int m);
    repeat (n) begin
      @(negedge clk);
      in_valid = (($urandom % 100) < vpct);
      in_i = pick(m);
      in_q = pick(m);
      lut_we = (($urandom % 100) < wpct);
      lut_waddr = 8'($urandom);
      lut_wgain_i = 16'($urandom);
      lut_wgain_q = 16'($urandom);
      tap_we = (($urandom % 100) < tpct);
      tap_sel = 2'($urandom);
      tap_wdata = 8'($urandom);
    end
    idle(8);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state at the outputs
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(out_i == 0 && out_q == 0, "R1 out", out_i, 0);
    chk(fb_addr == 0 && fb_gain_i == 0 && fb_gain_q == 0, "R1 fb", fb_gain_i, 0);
    rst_n = 1;
    idle(2);

    // R1, R3, R10: memory mode straight after reset must behave like direct mode
    mem_en = 1;
    stream(200, 70, 0, 0, 0);
    mem_en = 0;

    // R3: weights are ignored while mem_en is low
    for (int k = 0; k < 4; k++) wr_tap(k, int'($urandom % 256));
    idle(2);
    stream(200, 80, 0, 0, 0);

    // R4, R5: random table, random samples
    for (int d = 0; d < 256; d++) wr_lut(d, int'(16'($urandom)), int'(16'($urandom)));
    idle(2);
    stream(400, 85, 0, 0, 0);

    // R5: saturation at full-scale inputs (address 255)
    wr_lut(255, 16'h7fff, 16'h7fff); idle(2);
    stream(30, 100, 0, 0, 1);
    wr_lut(255, 16'h8000, 16'h8000); idle(2);
    stream(30, 100, 0, 0, 1);
    wr_lut(255, 16'h8000, 0); idle(2);
    stream(30, 100, 0, 0, 1);

    // R5: rounding of half-LSB results (address 0, gain 0.5)
    wr_lut(0, 16'h2000, 16'h2000); idle(2);
    stream(60, 100, 0, 0, 2);

    // R3: weighted sum saturates to the top entry
    mem_en = 1;
    for (int k = 0; k < 4; k++) wr_tap(k, 255);
    idle(2);
    stream(40, 100, 0, 0, 1);

    // R8, R9: live table and weight writes while streaming in memory mode
    stream(600, 75, 40, 15, 0);
    mem_en = 0;
    stream(300, 90, 50, 20, 0);

    // R8: same-edge write and read of one entry returns the old gain
    wr_lut(0, 16'h4000, 0);
    idle(3);
    @(negedge clk); in_valid = 1; in_i = 16'sd100; in_q = 0;
    @(negedge clk); in_valid = 0;
    @(negedge clk); lut_we = 1; lut_waddr = 0; lut_wgain_i = 16'h2000; lut_wgain_q = 0;
    @(negedge clk); lut_we = 0;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1 && out_i == 16'sd100, "R8 collision old", out_i, 100);
    idle(2);
    @(negedge clk); in_valid = 1; in_i = 16'sd100; in_q = 0;
    @(negedge clk); in_valid = 0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1 && out_i == 16'sd50, "R8 after write", out_i, 50);
    idle(8);

    done = 1;
    summary();
    $finish;
  end
endmodule